// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 40-bit physical address. It walks a radix tree of translation tables held in memory, one level at a time. Each table is one 4 KB page of 512 eight-byte entries. The first table comes from a root page number supplied with the request. Each entry read supplies the page number of the next table. The fourth entry supplies the page number of the 4 KB frame.

A requester presents a virtual address together with the following:
- an access kind: read, write or instruction fetch;
- a user/supervisor flag;
- the root page;
- a switch that turns execute-disable checking on.

The walker reads entries through a 64-bit memory read port with valid/ready requests and a response strobe. It handles only one translation at a time. It finishes with a one-cycle done strobe that carries either the physical address or a fault code and the level at which the walk stopped.

A walk can stop early. An address that is not sign-extended is rejected without touching memory. A missing entry ends the walk at its level, and so does an entry with reserved bits set. Write, user and execute rights are collected across all four levels and judged once the last entry arrives.

Top module: `pt_walker`

## Requirements
- R1: The address of the entry read at level L (0 is the top) is the table page number times 4096 plus 8 times the index field of that level. The index fields are virtual-address bits 47:39, 38:30, 29:21 and 20:12 for levels 0 to 3. Level 0 uses `root_page` as the table page. Every entry address has bits 2:0 equal to zero.
- R2: A request is non-canonical when virtual-address bits 63:47 are not all equal. Such a request issues no memory read. It finishes with done one cycle after acceptance, with fault_code 1, fault_level 0 and phys_addr 0. An address whose bits 63:47 are all ones is translated normally.
- R3: While mem_req_valid is high and mem_req_ready is low, the request and its address are held unchanged into the next cycle.
- R4: An entry whose bit 0 (present) is clear ends the walk with fault_code 2. fault_level is set to that entry's level, and no further memory read is made.
- R5: A present entry with any of bits 51:40 set ends the walk with fault_code 3 and fault_level set to that entry's level.
- R6: The table page for level L+1, and the frame page after level 3, is taken from bits 39:12 of the entry read at level L.
- R7: A user request (req_user=1) faults with fault_code 4 when bit 2 (user) is clear in any of the four entries. This check takes priority over R8 and R9.
- R8: A write request (req_kind=1) faults with fault_code 5 when bit 1 (writable) is clear in any of the four entries. Reads and fetches are not affected by bit 1.
- R9: A fetch request (req_kind=2) with nx_enable=1 faults with fault_code 6 when bit 63 is set in any of the four entries. With nx_enable=0, or for any other access kind, bit 63 has no effect. req_kind 3 behaves as a read.
- R10: A walk that does not fault ends with fault_code 0. fault_level is 3, and phys_addr is the frame page from the last entry joined with virtual-address bits 11:0. Faults 4 to 6 also report fault_level 3.
- R11: done is high for exactly one cycle per accepted request. phys_addr is 0 whenever fault_code is not 0. req_ready is low from the cycle after acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 = user-mode access |
| root_page | input | 28 | Page number of the top-level table |
| nx_enable | input | 1 | Enables execute-disable checking |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 40 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion strobe |
| fault_code | output | 3 | 0 none, 1 non-canonical, 2 not present, 3 reserved bits, 4 user, 5 write, 6 execute |
| fault_level | output | 2 | Level where the walk stopped |
| phys_addr | output | 40 | Translated address, 0 on a fault |

## Verification
A wrong level counter or table base shows at the memory port first. The next entry address carries the wrong index or page in the very cycle the request is raised, well before any result appears. Errors in the collected rights stay hidden until the fourth response arrives. They then show as a wrong fault code in the done cycle, so every rights case is a full four-read walk with one level's bit changed. An early-exit error shows as an extra memory read, or as a wrong level in the done cycle right after the failing response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_t;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_NONCAN  = 3'd1,
    FLT_ABSENT  = 3'd2,
    FLT_RSVD    = 3'd3,
    FLT_USER    = 3'd4,
    FLT_WRITE   = 3'd5,
    FLT_EXEC    = 3'd6
  } walk_fault_t;

  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;
  localparam int RSVD_TOP     = 51;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int VA_W   = 64,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  localparam int IMPL_W = OFF_W + LEVELS * IDX_W
) (
  input  logic [VA_W-1:0]                 vaddr,
  output logic                            canonical,
  output logic [LEVELS-1:0][IDX_W-1:0]    idx,
  output logic [OFF_W-1:0]                offset
);

  logic [VA_W-IMPL_W:0] upper;

  assign upper     = vaddr[VA_W-1:IMPL_W-1];
  assign canonical = (&upper) | ~(|upper);
  assign offset    = vaddr[OFF_W-1:0];

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx[l] = vaddr[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
  end

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int ENT_W = 64,
  parameter int PA_W  = 40,
  parameter int OFF_W = 12
) (
  input  logic [ENT_W-1:0]      entry,
  output logic                  present,
  output logic                  rsvd_bad,
  output logic                  wr_ok,
  output logic                  usr_ok,
  output logic                  no_exec,
  output logic [PA_W-OFF_W-1:0] page
);

  assign present  = entry[BIT_PRESENT];
  assign wr_ok    = entry[BIT_WRITABLE];
  assign usr_ok   = entry[BIT_USER];
  assign rsvd_bad = |entry[RSVD_TOP:PA_W];
  assign no_exec  = entry[ENT_W-1];
  assign page     = entry[PA_W-1:OFF_W];

endmodule

// File: rtl/ptw_perm_eval.sv
module ptw_perm_eval
  import ptw_pkg::*;
(
  input  logic       wr_all,
  input  logic       usr_all,
  input  logic       nx_any,
  input  logic [1:0] kind,
  input  logic       user,
  input  logic       nx_en,
  output logic [2:0] code
);

  always_comb begin
    code = FLT_NONE;
    if (user && !usr_all)
      code = FLT_USER;
    else if (kind == KIND_WRITE && !wr_all)
      code = FLT_WRITE;
    else if (kind == KIND_FETCH && nx_en && nx_any)
      code = FLT_EXEC;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int ENT_W  = 64,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  localparam int PG_W   = PA_W - OFF_W,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int ENT_SH = $clog2(ENT_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic [PG_W-1:0]   root_page,
  input  logic              nx_enable,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic [2:0]        fault_code,
  output logic [LVL_W-1:0]  fault_level,
  output logic [PA_W-1:0]   phys_addr
);

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_t             state;
  logic [VA_W-1:0]         va_q;
  logic [1:0]              kind_q;
  logic                    user_q;
  logic                    nx_q;
  logic [LVL_W-1:0]        lvl_q;
  logic                    acc_wr;
  logic                    acc_usr;
  logic                    acc_nx;

  logic [VA_W-1:0]              va_sel;
  logic                         va_canon;
  logic [LEVELS-1:0][IDX_W-1:0] va_idx;
  logic [OFF_W-1:0]             va_off;

  logic              pte_present;
  logic              pte_rsvd;
  logic              pte_wr;
  logic              pte_usr;
  logic              pte_nx;
  logic [PG_W-1:0]   pte_page;

  logic              wr_all;
  logic              usr_all;
  logic              nx_any;
  logic [2:0]        perm_code;
  logic [LVL_W-1:0]  lvl_next;

  function automatic logic [PA_W-1:0] entry_addr(input logic [PG_W-1:0] pg,
                                                 input logic [IDX_W-1:0] ix);
    return {pg, {OFF_W{1'b0}}} | PA_W'({ix, {ENT_SH{1'b0}}});
  endfunction

  assign va_sel    = (state == ST_IDLE) ? req_vaddr : va_q;
  assign req_ready = (state == ST_IDLE) && !done;
  assign lvl_next  = lvl_q + 1'b1;
  assign wr_all    = acc_wr & pte_wr;
  assign usr_all   = acc_usr & pte_usr;
  assign nx_any    = acc_nx | pte_nx;

  ptw_va_split #(
    .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_split (
    .vaddr(va_sel), .canonical(va_canon), .idx(va_idx), .offset(va_off)
  );

  ptw_pte_check #(
    .ENT_W(ENT_W), .PA_W(PA_W), .OFF_W(OFF_W)
  ) u_pte (
    .entry(mem_rsp_data), .present(pte_present), .rsvd_bad(pte_rsvd),
    .wr_ok(pte_wr), .usr_ok(pte_usr), .no_exec(pte_nx), .page(pte_page)
  );

  ptw_perm_eval u_perm (
    .wr_all(wr_all), .usr_all(usr_all), .nx_any(nx_any),
    .kind(kind_q), .user(user_q), .nx_en(nx_q), .code(perm_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      va_q          <= '0;
      kind_q        <= '0;
      user_q        <= 1'b0;
      nx_q          <= 1'b0;
      lvl_q         <= '0;
      acc_wr        <= 1'b1;
      acc_usr       <= 1'b1;
      acc_nx        <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done          <= 1'b0;
      fault_code    <= FLT_NONE;
      fault_level   <= '0;
      phys_addr     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            va_q        <= req_vaddr;
            kind_q      <= req_kind;
            user_q      <= req_user;
            nx_q        <= nx_enable;
            lvl_q       <= '0;
            acc_wr      <= 1'b1;
            acc_usr     <= 1'b1;
            acc_nx      <= 1'b0;
            fault_level <= '0;
            phys_addr   <= '0;
            if (!va_canon) begin
              done       <= 1'b1;
              fault_code <= FLT_NONCAN;
            end else begin
              state         <= ST_ISSUE;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= entry_addr(root_page, va_idx[0]);
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!pte_present || pte_rsvd) begin
              done        <= 1'b1;
              fault_code  <= pte_present ? FLT_RSVD : FLT_ABSENT;
              fault_level <= lvl_q;
              phys_addr   <= '0;
              state       <= ST_IDLE;
            end else if (lvl_q == LAST_LVL) begin
              done        <= 1'b1;
              fault_code  <= perm_code;
              fault_level <= lvl_q;
              phys_addr   <= (perm_code == FLT_NONE) ? {pte_page, va_off} : '0;
              state       <= ST_IDLE;
            end else begin
              lvl_q         <= lvl_next;
              acc_wr        <= wr_all;
              acc_usr       <= usr_all;
              acc_nx        <= nx_any;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= entry_addr(pte_page, va_idx[lvl_next]);
              state         <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int IMPL_W = OFF_W + LEVELS * IDX_W
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             done,
  input logic [2:0]       fault_code,
  input logic [LVL_W-1:0] fault_level,
  input logic [PA_W-1:0]  phys_addr
);

  logic             accept;
  logic             in_canon;
  logic [OFF_W-1:0] off_seen;

  assign accept   = req_valid && req_ready;
  assign in_canon = (&req_vaddr[VA_W-1:IMPL_W-1]) || !(|req_vaddr[VA_W-1:IMPL_W-1]);

  always_ff @(posedge clk) begin
    if (rst)         off_seen <= '0;
    else if (accept) off_seen <= req_vaddr[OFF_W-1:0];
  end

  AST_NONCANON_FAST: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_canon) |=> (done && fault_code == 3'd1 && fault_level == '0 && !mem_req_valid)); // R2

  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'd0)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || done) |-> !req_ready); // R11

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code != 3'd0) |-> (phys_addr == '0)); // R11

  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code == 3'd0) |-> (phys_addr[OFF_W-1:0] == off_seen)); // R10

endmodule

bind pt_walker ptw_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .fault_code(fault_code),
  .fault_level(fault_level), .phys_addr(phys_addr)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [27:0] root_page = '0;
  logic        nx_enable = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [2:0]  fault_code;
  logic [1:0]  fault_level;
  logic [39:0] phys_addr;

  always #2.5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user),
    .root_page(root_page), .nx_enable(nx_enable),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault_code(fault_code),
    .fault_level(fault_level), .phys_addr(phys_addr)
  );

  typedef struct {
    logic [2:0]  code;
    logic [1:0]  lvl;
    logic [39:0] pa;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  logic [39:0] hs_q[$];
  logic [63:0] pmem [logic [39:0]];
  int          total = 0;
  int          bad = 0;
  int          done_cnt = 0;
  int          hold_viol = 0;
  int          cyc = 0;
  logic        stall = 1'b0;
  logic        hs_seen = 1'b0;
  logic [39:0] hs_addr = '0;
  logic        prev_wait = 1'b0;
  logic [39:0] prev_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] vidx(input logic [63:0] va, input int l);
    return va[47 - 9*l -: 9];
  endfunction

  function automatic logic [63:0] pte(input logic [27:0] pg, input logic [2:0] f,
                                      input logic xd, input logic rsv);
    return {xd, 11'b0, (rsv ? 12'h001 : 12'h000), pg, 9'b0, f};
  endfunction

  // fl holds three flag bits per level, level 0 in the lowest digit
  task automatic build(input logic [27:0] root, input logic [63:0] va,
                       input logic [11:0] fl, input logic [3:0] xdm,
                       input logic [3:0] rsvm, input logic [27:0] frame);
    for (int l = 0; l < 4; l++) begin
      logic [27:0] nxt;
      nxt = (l < 3) ? root + 28'(l + 1) : frame;
      pmem[{root + 28'(l), vidx(va, l), 3'b000}] = pte(nxt, fl[3*l +: 3], xdm[l], rsvm[l]);
    end
  endtask

  task automatic issue(input logic [27:0] root, input logic [63:0] va,
                       input logic [1:0] kind, input logic user, input logic nx,
                       input logic [2:0] ecode, input logic [1:0] elvl,
                       input logic [39:0] epa, input string tag);
    exp_t e;
    int   n;
    while (!req_ready) @(negedge clk);
    e.code = ecode; e.lvl = elvl; e.pa = epa; e.tag = tag;
    sbq.push_back(e);
    hs_q.delete();
    n = done_cnt;
    root_page = root; req_vaddr = va; req_kind = kind;
    req_user = user; nx_enable = nx; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", {tag, " ready low after accept"}, 64'(req_ready), 64'd0);
    while (done_cnt == n) @(negedge clk);
  endtask

  // memory model: captures handshakes, answers two cycles later
  always @(posedge clk) begin
    hs_seen <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      hs_addr <= mem_req_addr;
      hs_q.push_back(mem_req_addr);
    end
    if (!rst && prev_wait && (!mem_req_valid || mem_req_addr != prev_addr))
      hold_viol <= hold_viol + 1;
    prev_wait <= mem_req_valid && !mem_req_ready;
    prev_addr <= mem_req_addr;
    cyc <= cyc + 1;
  end

  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = stall ? cyc[0] : 1'b1;
      if (hs_seen) begin
        logic [39:0] a;
        a = hs_addr;
        @(negedge clk);
        mem_req_ready = stall ? cyc[0] : 1'b1;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pmem.exists(a) ? pmem[a] : 64'd0;
        @(negedge clk);
        mem_req_ready = stall ? cyc[0] : 1'b1;
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(fault_code == e.code, e.tag, "fault_code", 64'(fault_code), 64'(e.code));
        chk(fault_level == e.lvl, e.tag, "fault_level", 64'(fault_level), 64'(e.lvl));
        chk(phys_addr == e.pa, e.tag, "phys_addr", 64'(phys_addr), 64'(e.pa));
      end
      done_cnt++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [63:0] VA1 = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] VA2 = 64'hFFFF_8000_0010_2FFF;
  localparam logic [63:0] VA3 = 64'h0000_7F00_0A0B_C123;

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "reset req_ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0 && mem_req_valid == 1'b0, "R11", "reset done/mem_req_valid",
        64'({done, mem_req_valid}), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R6 R10: plain supervisor read
    build(28'h100, VA1, 12'o7777, 4'b0000, 4'b0000, 28'h0ABCDE);
    issue(28'h100, VA1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd3, {28'h0ABCDE, VA1[11:0]}, "R10");
    chk(hs_q.size() == 4, "R1", "four reads", 64'(hs_q.size()), 64'd4);
    chk(hs_q[0] == {28'h100, vidx(VA1, 0), 3'b000}, "R1", "level0 addr",
        64'(hs_q[0]), 64'({28'h100, vidx(VA1, 0), 3'b000}));
    chk(hs_q[2] == {28'h102, vidx(VA1, 2), 3'b000}, "R6", "level2 addr",
        64'(hs_q[2]), 64'({28'h102, vidx(VA1, 2), 3'b000}));
    chk(hs_q[3] == {28'h103, vidx(VA1, 3), 3'b000}, "R6", "level3 addr",
        64'(hs_q[3]), 64'({28'h103, vidx(VA1, 3), 3'b000}));

    // R2: upper-half canonical address, user write, all rights
    build(28'h110, VA2, 12'o7777, 4'b0000, 4'b0000, 28'h0000042);
    issue(28'h110, VA2, 2'd1, 1'b1, 1'b0, 3'd0, 2'd3, {28'h0000042, VA2[11:0]}, "R2");

    // R4: not present at level 2
    build(28'h120, VA1, 12'o7077, 4'b0000, 4'b0000, 28'h0000055);
    issue(28'h120, VA1, 2'd0, 1'b0, 1'b0, 3'd2, 2'd2, 40'd0, "R4");
    chk(hs_q.size() == 3, "R4", "reads before stop", 64'(hs_q.size()), 64'd3);

    // R5: reserved bits at level 1
    build(28'h130, VA1, 12'o7777, 4'b0000, 4'b0010, 28'h0000066);
    issue(28'h130, VA1, 2'd0, 1'b0, 1'b0, 3'd3, 2'd1, 40'd0, "R5");
    chk(hs_q.size() == 2, "R5", "reads before stop", 64'(hs_q.size()), 64'd2);

    // R7: user read, level 3 supervisor-only
    build(28'h140, VA3, 12'o3777, 4'b0000, 4'b0000, 28'h0000077);
    issue(28'h140, VA3, 2'd0, 1'b1, 1'b0, 3'd4, 2'd3, 40'd0, "R7");
    // R7 priority over write: level 0 read-only, level 3 supervisor-only
    build(28'h150, VA3, 12'o3775, 4'b0000, 4'b0000, 28'h0000088);
    issue(28'h150, VA3, 2'd1, 1'b1, 1'b0, 3'd4, 2'd3, 40'd0, "R7");

    // R8: supervisor write, level 0 read-only; read passes
    build(28'h160, VA3, 12'o7775, 4'b0000, 4'b0000, 28'h0000099);
    issue(28'h160, VA3, 2'd1, 1'b0, 1'b0, 3'd5, 2'd3, 40'd0, "R8");
    issue(28'h160, VA3, 2'd0, 1'b0, 1'b0, 3'd0, 2'd3, {28'h0000099, VA3[11:0]}, "R8");

    // R9: execute-disable at level 1
    build(28'h170, VA1, 12'o7777, 4'b0010, 4'b0000, 28'h00000AA);
    issue(28'h170, VA1, 2'd2, 1'b0, 1'b1, 3'd6, 2'd3, 40'd0, "R9");
    issue(28'h170, VA1, 2'd2, 1'b0, 1'b0, 3'd0, 2'd3, {28'h00000AA, VA1[11:0]}, "R9");
    issue(28'h170, VA1, 2'd0, 1'b0, 1'b1, 3'd0, 2'd3, {28'h00000AA, VA1[11:0]}, "R9");

    // R2: non-canonical addresses
    issue(28'h100, 64'h0001_0000_0000_0000, 2'd0, 1'b0, 1'b0, 3'd1, 2'd0, 40'd0, "R2");
    chk(hs_q.size() == 0, "R2", "no memory read", 64'(hs_q.size()), 64'd0);
    issue(28'h100, 64'hFFFF_0000_0000_0000, 2'd0, 1'b0, 1'b0, 3'd1, 2'd0, 40'd0, "R2");
    chk(hs_q.size() == 0, "R2", "no memory read", 64'(hs_q.size()), 64'd0);

    // R3: memory port stalls every other cycle
    stall = 1'b1;
    issue(28'h100, VA1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd3, {28'h0ABCDE, VA1[11:0]}, "R3");
    stall = 1'b0;
    chk(hold_viol == 0, "R3", "request held while stalled", 64'(hold_viol), 64'd0);
    chk(sbq.size() == 0, "R11", "all results seen", 64'(sbq.size()), 64'd0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule